// File: doc/BRIEF.md
# Leveled Interrupt Request Arbiter

The arbiter picks one service request out of a vector of sixteen sources and decides whether the processor should take it. Each source carries a request line, an individual enable, a 4-bit priority level and a 2-bit group priority. A single global enable stands over all of them. A source competes only while it requests, its own enable is set, the global enable is set and its level is non-zero.

Among the competing sources, the highest level wins. A tie in level is settled by the higher group priority. A remaining tie goes to the lowest source index. Only this winner is then compared with the processor's current priority level. It is granted only when its level is strictly above that level.

The decision is registered, so the grant and the winner index appear one clock after the inputs they were formed from. A request that is blocked is not remembered. If the conditions later allow it and the request is no longer present, no grant follows. Vector fetch, context saving and the data-transfer engine sit outside this block.

Top module: `lvl_irq_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grantValid` is 0 and `grantIdx` is 0.
- R2: If `globalEn` is 0 at a clock edge, `grantValid` is 0 after that edge, whatever the other inputs are.
- R3: A source whose `reqVec` bit or `enVec` bit is 0 at an edge can never be the granted index after that edge. A request seen while its source was blocked is not stored and causes no later grant.
- R4: Among eligible sources, the one with the numerically largest 4-bit level (source i at `lvlFlat[4i+3:4i]`) wins.
- R5: Among eligible sources of equal level, the one with the larger 2-bit group priority (source i at `grpFlat[2i+1:2i]`) wins.
- R6: Among eligible sources with equal level and equal group, the lowest index wins.
- R7: The winner is granted only when its level is strictly greater than `cpuLvl`. If it is equal or lower, `grantValid` is 0.
- R8: A source whose level is 0 is never granted, even when `cpuLvl` is 0.
- R9: `grantValid` and `grantIdx` change only at a clock edge. They reflect the inputs sampled at that edge, so there is one cycle of latency.
- R10: Whenever `grantValid` is 0, `grantIdx` is 0. When `grantValid` is 1, `grantIdx` is the binary index of the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqVec | input | 16 | Request line per source |
| enVec | input | 16 | Individual enable per source |
| lvlFlat | input | 64 | 4-bit priority level per source, source i in bits 4i+3..4i |
| grpFlat | input | 32 | 2-bit group priority per source, source i in bits 2i+1..2i |
| globalEn | input | 1 | Master enable for all sources |
| cpuLvl | input | 4 | Current processor priority level |
| grantValid | output | 1 | Registered grant |
| grantIdx | output | 4 | Registered winner index, 0 when no grant |

## Verification
The single-source sweep drives one source at every level against every CPU level, for all sixteen positions. It separates the strict comparison from greater-or-equal, shows that level 0 is excluded, and shows that the index encoding is correct at every position. Mixed random patterns, with equal levels made likely, compare the winner against an arithmetic model of the level, group and index ordering. This exposes a wrong tie-break direction. Directed cases toggle the global and individual enables, pulse a request while it is disabled, and sample before and after the edge. These cases separate masking from storing and show that the output really is registered.

// File: rtl/lvl_arb_pkg.sv
package lvl_arb_pkg;
  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic grantSet;   // register a grant this edge
    logic idxLoad;    // register the winner index (else clear it)
  } arbStrobe_t;
endpackage

// File: rtl/lvl_arb_datapath.sv
module lvl_arb_datapath
  import lvl_arb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       reqVec,
  input  logic [NUM_SRC-1:0]       enVec,
  input  logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  input  logic [NUM_SRC*GRP_W-1:0] grpFlat,
  input  logic                     globalEn,
  input  arbStrobe_t               strobe,
  output logic                     winFound,
  output logic [LVL_W-1:0]         winLvl,
  output logic                     grantValid,
  output logic [IDX_W-1:0]         grantIdx
);
  localparam int KEY_W = LVL_W + GRP_W;

  logic [NUM_SRC-1:0] eligVec;
  logic [KEY_W-1:0]   keyArr [NUM_SRC];

  // Per-source eligibility and ordering key {level, group}
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign eligVec[s] = reqVec[s] && enVec[s] && globalEn &&
                        (lvlFlat[s*LVL_W +: LVL_W] != '0);
    assign keyArr[s]  = {lvlFlat[s*LVL_W +: LVL_W], grpFlat[s*GRP_W +: GRP_W]};
  end

  logic [KEY_W-1:0] bestKey;
  logic [IDX_W-1:0] bestIdx;

  // Ascending scan; replace only on a strictly larger key, so ties keep the lower index
  always_comb begin
    winFound = 1'b0;
    bestKey  = '0;
    bestIdx  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (eligVec[s] && (!winFound || keyArr[s] > bestKey)) begin
        winFound = 1'b1;
        bestKey  = keyArr[s];
        bestIdx  = IDX_W'(s);
      end
    end
  end

  assign winLvl = bestKey[KEY_W-1 -: LVL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
    end else begin
      grantValid <= strobe.grantSet;
      grantIdx   <= strobe.idxLoad ? bestIdx : '0;
    end
  end
endmodule

// File: rtl/lvl_arb_control.sv
module lvl_arb_control
  import lvl_arb_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             winFound,
  input  logic [LVL_W-1:0] winLvl,
  input  logic [LVL_W-1:0] cpuLvl,
  output arbStrobe_t       strobe
);
  logic aboveCpu;

  // Only the arbitration winner is compared with the running CPU level
  assign aboveCpu = winLvl > cpuLvl;

  always_comb begin
    strobe          = '0;
    strobe.grantSet = winFound && aboveCpu;
    strobe.idxLoad  = winFound && aboveCpu;
  end
endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter
  import lvl_arb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       reqVec,
  input  logic [NUM_SRC-1:0]       enVec,
  input  logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  input  logic [NUM_SRC*GRP_W-1:0] grpFlat,
  input  logic                     globalEn,
  input  logic [LVL_W-1:0]         cpuLvl,
  output logic                     grantValid,
  output logic [IDX_W-1:0]         grantIdx
);
  arbStrobe_t       strobe;
  logic             winFound;
  logic [LVL_W-1:0] winLvl;

  lvl_arb_datapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .enVec(enVec),
    .lvlFlat(lvlFlat), .grpFlat(grpFlat), .globalEn(globalEn),
    .strobe(strobe), .winFound(winFound), .winLvl(winLvl),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );

  lvl_arb_control #(.LVL_W(LVL_W)) u_control (
    .winFound(winFound), .winLvl(winLvl), .cpuLvl(cpuLvl), .strobe(strobe)
  );
endmodule

// File: rtl/lvl_arb_checker.sv
module lvl_arb_checker #(
  parameter int NUM_SRC = 16,
  parameter int LVL_W   = 4,
  parameter int GRP_W   = 2,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC-1:0]       reqVec,
  input logic [NUM_SRC-1:0]       enVec,
  input logic [NUM_SRC*LVL_W-1:0] lvlFlat,
  input logic [NUM_SRC*GRP_W-1:0] grpFlat,
  input logic                     globalEn,
  input logic [LVL_W-1:0]         cpuLvl,
  input logic                     grantValid,
  input logic [IDX_W-1:0]         grantIdx
);
  logic [NUM_SRC-1:0]       prevElig;
  logic [NUM_SRC*LVL_W-1:0] prevLvl;
  logic [LVL_W-1:0]         prevCpu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevElig <= '0;
      prevLvl  <= '0;
      prevCpu  <= '1;
    end else begin
      prevElig <= reqVec & enVec;
      prevLvl  <= lvlFlat;
      prevCpu  <= cpuLvl;
    end
  end

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !globalEn |=> !grantValid); // R2
  AST_NO_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((reqVec & enVec) == '0) |=> !grantValid); // R3
  AST_GRANT_FROM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> prevElig[grantIdx]); // R3
  AST_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (prevLvl[grantIdx*LVL_W +: LVL_W] > prevCpu)); // R7
  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (prevLvl[grantIdx*LVL_W +: LVL_W] != '0)); // R8
  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    !grantValid |-> (grantIdx == '0)); // R10
endmodule

bind lvl_irq_arbiter lvl_arb_checker #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .GRP_W(GRP_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/test_lvl_irq_arbiter.sv
module test_lvl_irq_arbiter;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reqVec = '0, enVec = '0;
  logic [63:0] lvlFlat = '0;
  logic [31:0] grpFlat = '0;
  logic        globalEn = 1'b0;
  logic [3:0]  cpuLvl = '0;
  logic        grantValid;
  logic [3:0]  grantIdx;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvl_irq_arbiter i_lvl_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .enVec(enVec),
    .lvlFlat(lvlFlat), .grpFlat(grpFlat), .globalEn(globalEn),
    .cpuLvl(cpuLvl), .grantValid(grantValid), .grantIdx(grantIdx)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result from the requirements: eligible, largest {level,group}, lowest index, strictly above CPU
  task automatic model(output int expValid, output int expIdx);
    int bestKey = -1;
    int bestIdx = 0;
    for (int s = 0; s < N; s++) begin
      int lv = int'(lvlFlat[s*4 +: 4]);
      int key = lv * 4 + int'(grpFlat[s*2 +: 2]);
      if (reqVec[s] && enVec[s] && globalEn && lv != 0 && key > bestKey) begin
        bestKey = key;
        bestIdx = s;
      end
    end
    if (bestKey >= 0 && (bestKey / 4) > int'(cpuLvl)) begin
      expValid = 1; expIdx = bestIdx;
    end else begin
      expValid = 0; expIdx = 0;
    end
  endtask

  // Inputs are already driven (after a negedge); cross one edge and compare at the next negedge
  task automatic stepCheck(input string req);
    int ev, ei;
    model(ev, ei);
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, int'(grantValid), ev);
    check({req, " index"}, int'(grantIdx), ei);
  endtask

  task automatic clearAll();
    reqVec = '0; enVec = '0; lvlFlat = '0; grpFlat = '0;
    globalEn = 1'b1; cpuLvl = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    reqVec = '1; enVec = '1; lvlFlat = '1; globalEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(grantValid), 0);
    check("R1 index in reset", int'(grantIdx), 0);
    clearAll();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(grantValid), 0);
    check("R1 index after reset", int'(grantIdx), 0);

    // R9: output holds before the edge, updates after it
    reqVec[5] = 1'b1; enVec[5] = 1'b1; lvlFlat[5*4 +: 4] = 4'd9; cpuLvl = 4'd2;
    #1;
    check("R9 no change before edge", int'(grantValid), 0);
    stepCheck("R9");
    check("R9 registered index", int'(grantIdx), 5);

    // R2: global enable clear blocks everything
    globalEn = 1'b0;
    stepCheck("R2");
    check("R2 global off", int'(grantValid), 0);
    globalEn = 1'b1;

    // R3: disabled request is dropped, not stored
    enVec[5] = 1'b0;
    stepCheck("R3 disabled");
    reqVec[5] = 1'b0; enVec[5] = 1'b1;
    stepCheck("R3 not stored");
    check("R3 no late grant", int'(grantValid), 0);

    // R8: level-zero source with CPU at 0
    clearAll();
    reqVec[3] = 1'b1; enVec[3] = 1'b1; grpFlat[3*2 +: 2] = 2'd3;
    stepCheck("R8");
    check("R8 level zero", int'(grantValid), 0);

    // R4/R5/R6 directed ordering
    clearAll();
    reqVec = 16'hFFFF; enVec = 16'hFFFF;
    for (int s = 0; s < N; s++) lvlFlat[s*4 +: 4] = 4'd4;
    lvlFlat[12*4 +: 4] = 4'd7;
    stepCheck("R4 level");
    check("R4 highest level", int'(grantIdx), 12);
    lvlFlat[12*4 +: 4] = 4'd4;
    grpFlat[9*2 +: 2] = 2'd2; grpFlat[14*2 +: 2] = 2'd2;
    stepCheck("R5 group");
    check("R5/R6 group then index", int'(grantIdx), 9);
    grpFlat = '0;
    stepCheck("R6 index");
    check("R6 lowest index", int'(grantIdx), 0);
    cpuLvl = 4'd4;
    stepCheck("R7 equal");
    check("R7 equal level blocked", int'(grantValid), 0);

    // R7/R8/R10 sweep: one source, every position, level and CPU level
    for (int s = 0; s < N; s++)
      for (int lv = 0; lv < 16; lv++)
        for (int cl = 0; cl < 16; cl++) begin
          clearAll();
          reqVec[s] = 1'b1; enVec[s] = 1'b1;
          lvlFlat[s*4 +: 4] = 4'(lv); cpuLvl = 4'(cl);
          stepCheck("R7 R8 R10 sweep");
        end

    // R3/R4/R5/R6 mixed patterns, narrow level range to force ties
    for (int k = 0; k < 3000; k++) begin
      reqVec = 16'($urandom); enVec = 16'($urandom) | 16'($urandom);
      for (int s = 0; s < N; s++) lvlFlat[s*4 +: 4] = 4'(($urandom % 4) + (k % 13));
      grpFlat = $urandom;
      globalEn = ($urandom % 8) != 0;
      cpuLvl = 4'($urandom % 12);
      stepCheck("R3 R4 R5 R6 mixed");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule